// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This unit owns the paired HI and LO result registers of a 32-bit load/store core. Given a function code, two operand values and a start strobe, it forms signed or unsigned 2W-bit products, runs signed or unsigned restoring division, and serves the move-to and move-from operations on each half. A multiply lands in one clock. A divide shifts one quotient bit per cycle and keeps `busy` high while it runs.

The pipeline issues an operation by raising `opStart` for one cycle with the function code on `opFunct`. A move-from request returns its value on `readVal` in the same cycle. If a divide is still running, the unit raises `stall` instead, and the pipeline repeats the request once `busy` falls. Every width follows the `DATA_W` parameter.

Top module: `hilo_mdu`

## Requirements
- R1: After reset, HI and LO read as zero, and `busy` and `done` are low.
- R2: Function code 0x18 (signed multiply) writes the 2W-bit two's-complement product of rs and rt, upper half to HI and lower half to LO, visible one cycle after the start.
- R3: Function code 0x19 (unsigned multiply) writes the 2W-bit unsigned product of rs and rt, upper half to HI and lower half to LO.
- R4: Function code 0x1A (signed divide) with a nonzero divisor puts the quotient, truncated toward zero, in LO and the remainder, which carries the dividend's sign, in HI. The most negative value divided by minus one gives the most negative value and remainder zero.
- R5: Function code 0x1B (unsigned divide) with a nonzero divisor treats both operands as unsigned, quotient to LO and remainder to HI.
- R6: A divide by zero, signed or unsigned, sets LO to all ones and HI to the dividend's bit pattern, and raises no other indication.
- R7: A multiply pulses `done` for one cycle, in the cycle after the start, without raising `busy`. A divide holds `busy` high for DATA_W+1 cycles after the start cycle, and `done` rises for one cycle DATA_W+2 cycles after the start.
- R8: Function codes 0x11 and 0x13 copy rs into HI or LO respectively and leave the other half unchanged.
- R9: Function codes 0x10 and 0x12 present HI or LO respectively on `readVal` in the same cycle. `readValid` is high when the unit is idle. When a divide is running, `stall` is high and `readValid` is low.
- R10: A start of any code other than 0x10 or 0x12 while `busy` is high is ignored, so HI and LO afterwards hold the running divide's results.
- R11: A start with a function code outside the eight listed ones changes neither HI, LO, `busy` nor `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opStart | input | 1 | One-cycle operation request |
| opFunct | input | 6 | Function code of the request |
| rsVal | input | DATA_W | First operand (dividend, move source) |
| rtVal | input | DATA_W | Second operand (divisor) |
| readVal | output | DATA_W | Selected HI or LO value for a move-from |
| readValid | output | 1 | Move-from request served this cycle |
| stall | output | 1 | Move-from request must be repeated |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle pulse when a multiply or divide result has been written |

## Verification
The bench builds two copies side by side. One has DATA_W=4, which puts every operand pair of all four arithmetic codes within reach: the most negative value divided by minus one, every sign combination of truncation, and every divide by zero. The other uses the default width of 32 and replays the same sweep zero-extended. It also takes directed wide operands, such as unsigned quotients with the top bit set and full-range unsigned products. Because both copies run at once, the bench also compares the divide latency at the two widths and checks stalls, ignored starts and unknown codes.

// File: rtl/hilo_mdu_pkg.sv
package hilo_mdu_pkg;

  localparam logic [5:0] FN_MFHI  = 6'h10;
  localparam logic [5:0] FN_MTHI  = 6'h11;
  localparam logic [5:0] FN_MFLO  = 6'h12;
  localparam logic [5:0] FN_MTLO  = 6'h13;
  localparam logic [5:0] FN_MULT  = 6'h18;
  localparam logic [5:0] FN_MULTU = 6'h19;
  localparam logic [5:0] FN_DIV   = 6'h1A;
  localparam logic [5:0] FN_DIVU  = 6'h1B;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIX
  } mduState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadDiv;
    logic stepDiv;
    logic finishDiv;
    logic writeMul;
    logic writeHi;
    logic writeLo;
    logic signedOp;
  } mduCtl_t;

endpackage

// File: rtl/hilo_div_core.sv
module hilo_div_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         loadDiv,
  input  logic         stepDiv,
  input  logic         signedOp,
  input  logic [W-1:0] dividendIn,
  input  logic [W-1:0] divisorIn,
  output logic [W-1:0] quotOut,
  output logic [W-1:0] remOut
);

  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ONES = '1;

  logic [W-1:0] remReg, quoReg, divisorMag, dividendRaw;
  logic         negQuo, negRem, divZero;

  logic [W-1:0] aMag, bMag;
  logic [W:0]   shifted, trial;

  always_comb begin
    aMag    = (signedOp && dividendIn[W-1]) ? (~dividendIn + ONE) : dividendIn;
    bMag    = (signedOp && divisorIn[W-1])  ? (~divisorIn + ONE)  : divisorIn;
    shifted = {remReg, quoReg[W-1]};
    trial   = shifted - {1'b0, divisorMag};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remReg      <= '0;
      quoReg      <= '0;
      divisorMag  <= '0;
      dividendRaw <= '0;
      negQuo      <= 1'b0;
      negRem      <= 1'b0;
      divZero     <= 1'b1;
    end else if (loadDiv) begin
      remReg      <= '0;
      quoReg      <= aMag;
      divisorMag  <= bMag;
      dividendRaw <= dividendIn;
      negQuo      <= signedOp && (dividendIn[W-1] ^ divisorIn[W-1]);
      negRem      <= signedOp && dividendIn[W-1];
      divZero     <= (divisorIn == '0);
    end else if (stepDiv) begin
      if (!trial[W]) begin
        remReg <= trial[W-1:0];
        quoReg <= {quoReg[W-2:0], 1'b1};
      end else begin
        remReg <= shifted[W-1:0];
        quoReg <= {quoReg[W-2:0], 1'b0};
      end
    end
  end

  always_comb begin
    if (divZero) begin
      quotOut = ONES;
      remOut  = dividendRaw;
    end else begin
      quotOut = negQuo ? (~quoReg + ONE) : quoReg;
      remOut  = negRem ? (~remReg + ONE) : remReg;
    end
  end

  // R4: partial remainder always stays below the divisor magnitude
  p_rem_below_divisor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!divZero) |-> (remReg < divisorMag));

endmodule

// File: rtl/hilo_mdu_ctrl.sv
module hilo_mdu_ctrl
  import hilo_mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       opStart,
  input  logic [5:0] opFunct,
  output mduCtl_t    ctl,
  output logic       readHiSel,
  output logic       readValid,
  output logic       stall,
  output logic       busy,
  output logic       done
);

  localparam int CNT_W = (W > 2) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  mduState_e        state;
  logic [CNT_W-1:0] stepCnt;
  logic             accept, isMoveFrom;

  always_comb begin
    accept     = opStart && (state == ST_IDLE);
    isMoveFrom = (opFunct == FN_MFHI) || (opFunct == FN_MFLO);
    busy       = (state != ST_IDLE);
    readHiSel  = (opFunct == FN_MFHI);
    readValid  = opStart && isMoveFrom && !busy;
    stall      = opStart && isMoveFrom && busy;

    ctl.signedOp  = (opFunct == FN_MULT) || (opFunct == FN_DIV);
    ctl.writeMul  = accept && ((opFunct == FN_MULT) || (opFunct == FN_MULTU));
    ctl.loadDiv   = accept && ((opFunct == FN_DIV) || (opFunct == FN_DIVU));
    ctl.writeHi   = accept && (opFunct == FN_MTHI);
    ctl.writeLo   = accept && (opFunct == FN_MTLO);
    ctl.stepDiv   = (state == ST_RUN);
    ctl.finishDiv = (state == ST_FIX);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= ctl.writeMul || ctl.finishDiv;
      unique case (state)
        ST_IDLE: begin
          if (ctl.loadDiv) begin
            state   <= ST_RUN;
            stepCnt <= '0;
          end
        end
        ST_RUN: begin
          stepCnt <= stepCnt + CNT_W'(1);
          if (stepCnt == LAST) state <= ST_FIX;
        end
        ST_FIX:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: completion pulse never overlaps a running divide
  p_done_while_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7: busy only ever starts from a request
  p_busy_from_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(opStart));

  // R7: the fix-up cycle always follows the iteration phase
  p_fix_after_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIX) |-> ($past(state) == ST_RUN));

endmodule

// File: rtl/hilo_mdu_dpath.sv
module hilo_mdu_dpath
  import hilo_mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  mduCtl_t      ctl,
  input  logic         readHiSel,
  input  logic [W-1:0] rsVal,
  input  logic [W-1:0] rtVal,
  output logic [W-1:0] readVal
);

  localparam int PW = 2 * W;

  logic [W-1:0]  hiReg, loReg;
  logic [W-1:0]  quotVal, remVal;
  logic [PW-1:0] prodSel;

  hilo_div_core #(.W(W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .loadDiv    (ctl.loadDiv),
    .stepDiv    (ctl.stepDiv),
    .signedOp   (ctl.signedOp),
    .dividendIn (rsVal),
    .divisorIn  (rtVal),
    .quotOut    (quotVal),
    .remOut     (remVal)
  );

  // operands widened by sign or zero per request, one product either way
  always_comb begin
    logic [PW-1:0] aExt, bExt;
    aExt    = {{W{ctl.signedOp & rsVal[W-1]}}, rsVal};
    bExt    = {{W{ctl.signedOp & rtVal[W-1]}}, rtVal};
    prodSel = aExt * bExt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hiReg <= '0;
      loReg <= '0;
    end else begin
      if (ctl.writeMul) begin
        hiReg <= prodSel[PW-1:W];
        loReg <= prodSel[W-1:0];
      end
      if (ctl.finishDiv) begin
        hiReg <= remVal;
        loReg <= quotVal;
      end
      if (ctl.writeHi) hiReg <= rsVal;
      if (ctl.writeLo) loReg <= rsVal;
    end
  end

  assign readVal = readHiSel ? hiReg : loReg;

  // R10: iterations leave the visible pair untouched
  p_step_holds_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.stepDiv |=> ($stable(hiReg) && $stable(loReg)));

  // R8: a move into HI leaves LO alone, and the reverse
  p_move_hi_keeps_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.writeHi |=> $stable(loReg));
  p_move_lo_keeps_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.writeLo |=> $stable(hiReg));

endmodule

// File: rtl/hilo_mdu.sv
module hilo_mdu
  import hilo_mdu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opStart,
  input  logic [5:0]        opFunct,
  input  logic [DATA_W-1:0] rsVal,
  input  logic [DATA_W-1:0] rtVal,
  output logic [DATA_W-1:0] readVal,
  output logic              readValid,
  output logic              stall,
  output logic              busy,
  output logic              done
);

  mduCtl_t ctl;
  logic    readHiSel;

  hilo_mdu_ctrl #(.W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .opStart   (opStart),
    .opFunct   (opFunct),
    .ctl       (ctl),
    .readHiSel (readHiSel),
    .readValid (readValid),
    .stall     (stall),
    .busy      (busy),
    .done      (done)
  );

  hilo_mdu_dpath #(.W(DATA_W)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .readHiSel (readHiSel),
    .rsVal     (rsVal),
    .rtVal     (rtVal),
    .readVal   (readVal)
  );

  // R9: a move-from request is either served or stalled, never both
  p_read_or_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(readValid && stall));

endmodule

// File: tb/hilo_mdu_bench.sv
`timescale 1ns/1ps
module hilo_mdu_bench;

  localparam logic [5:0] F_MFHI = 6'h10, F_MTHI = 6'h11, F_MFLO = 6'h12, F_MTLO = 6'h13;
  localparam logic [5:0] F_MULT = 6'h18, F_MULTU = 6'h19, F_DIV = 6'h1A, F_DIVU = 6'h1B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opStart = 1'b0;
  logic [5:0]  opFunct = 6'h0;
  logic [31:0] rsIn = '0, rtIn = '0;

  logic [3:0]  readValS;
  logic [31:0] readValB;
  logic        readValidS, stallS, busyS, doneS;
  logic        readValidB, stallB, busyB, doneB;

  int nChk = 0, nFail = 0;
  logic [31:0] expHiS = '0, expLoS = '0, expHiB = '0, expLoB = '0;

  always #4 clk = ~clk;

  hilo_mdu #(.DATA_W(4)) u_hilo_mdu (
    .clk(clk), .rst_n(rst_n), .opStart(opStart), .opFunct(opFunct),
    .rsVal(rsIn[3:0]), .rtVal(rtIn[3:0]), .readVal(readValS),
    .readValid(readValidS), .stall(stallS), .busy(busyS), .done(doneS));

  hilo_mdu #(.DATA_W(32)) u_hilo_mdu_w32 (
    .clk(clk), .rst_n(rst_n), .opStart(opStart), .opFunct(opFunct),
    .rsVal(rsIn), .rtVal(rtIn), .readVal(readValB),
    .readValid(readValidB), .stall(stallB), .busy(busyB), .done(doneB));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // arithmetic model: returns {hi, lo} for a width w
  function automatic logic [63:0] model(input int w, input logic [5:0] f,
      input logic [31:0] a, input logic [31:0] b,
      input logic [31:0] oh, input logic [31:0] ol);
    longint unsigned mask, ua, ub, pu;
    longint sa, sb, p, q, r;
    logic [31:0] hi, lo;
    mask = (64'd1 << w) - 1;
    ua = {32'd0, a} & mask;
    ub = {32'd0, b} & mask;
    sa = ((ua >> (w - 1)) & 1) != 0 ? longint'(ua) - (longint'(1) << w) : longint'(ua);
    sb = ((ub >> (w - 1)) & 1) != 0 ? longint'(ub) - (longint'(1) << w) : longint'(ub);
    hi = oh; lo = ol;
    case (f)
      F_MULT: begin
        p = sa * sb;
        hi = 32'((longint'(p >>> w)) & longint'(mask));
        lo = 32'(p & longint'(mask));
      end
      F_MULTU: begin
        pu = ua * ub;
        hi = 32'((pu >> w) & mask);
        lo = 32'(pu & mask);
      end
      F_DIV, F_DIVU: begin
        if (ub == 0) begin
          hi = 32'(ua); lo = 32'(mask);
        end else if (f == F_DIV) begin
          q = sa / sb; r = sa % sb;
          hi = 32'(r & longint'(mask)); lo = 32'(q & longint'(mask));
        end else begin
          hi = 32'(ua % ub); lo = 32'(ua / ub);
        end
      end
      F_MTHI: hi = 32'(ua);
      F_MTLO: lo = 32'(ua);
      default: ;
    endcase
    return {hi, lo};
  endfunction

  task automatic updateExp(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] m;
    m = model(4, f, a, b, expHiS, expLoS);
    expHiS = m[63:32]; expLoS = m[31:0];
    m = model(32, f, a, b, expHiB, expLoB);
    expHiB = m[63:32]; expLoB = m[31:0];
  endtask

  task automatic waitIdle();
    int g = 0;
    while ((busyS || busyB) && g < 100) begin
      @(negedge clk);
      g++;
    end
  endtask

  task automatic doOp(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    opFunct = f; rsIn = a; rtIn = b; opStart = 1'b1;
    @(negedge clk);
    opStart = 1'b0;
    waitIdle();
    updateExp(f, a, b);
  endtask

  task automatic readCheck(input string tag);
    @(negedge clk);
    opFunct = F_MFHI; opStart = 1'b1;
    #1;
    chk({tag, " w4 HI"}, readValS, expHiS[3:0]);
    chk({tag, " w32 HI"}, readValB, expHiB);
    opFunct = F_MFLO;
    #1;
    chk({tag, " w4 LO"}, readValS, expLoS[3:0]);
    chk({tag, " w32 LO"}, readValB, expLoB);
    opStart = 1'b0;
  endtask

  function automatic string tagOf(input logic [5:0] f, input logic [31:0] b);
    if ((f == F_DIV || f == F_DIVU) && b[3:0] == 4'd0) return "R6";
    case (f)
      F_MULT:  return "R2";
      F_MULTU: return "R3";
      F_DIV:   return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    int doneAtS, doneAtB, busyRunS, busyRunB;
    logic [5:0] sweepOps [4];
    sweepOps = '{F_MULT, F_MULTU, F_DIV, F_DIVU};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 busy", {busyS, busyB}, 2'b00);
    chk("R1 done", {doneS, doneB}, 2'b00);
    readCheck("R1");

    // R8: moves into each half
    doOp(F_MTHI, 32'hA5A5_000C, 0);
    readCheck("R8 mthi");
    doOp(F_MTLO, 32'h1234_5673, 0);
    readCheck("R8 mtlo");

    // R2..R6: exhaustive sweep on the narrow copy, zero-extended on the wide one
    foreach (sweepOps[i]) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          doOp(sweepOps[i], 32'(a), 32'(b));
          readCheck(tagOf(sweepOps[i], 32'(b)));
        end
      end
    end

    // directed wide operands
    doOp(F_DIVU, 32'h8000_0000, 32'd2);   readCheck("R5 wide top bit");
    doOp(F_DIV, 32'd9, 32'd3);            readCheck("R4 nine by three");
    doOp(F_DIV, 32'hFFFF_FFF9, 32'd2);    readCheck("R4 negative dividend");
    doOp(F_DIV, 32'd7, 32'hFFFF_FFFE);    readCheck("R4 negative divisor");
    doOp(F_DIV, 32'h8000_0000, 32'hFFFF_FFFF); readCheck("R4 min by minus one");
    doOp(F_MULT, 32'd4, 32'd3);           readCheck("R2 four by three");
    doOp(F_MULT, 32'hFFFF_FFFD, 32'd5);   readCheck("R2 negative product");
    doOp(F_MULTU, 32'hFFFF_FFFF, 32'hFFFF_FFFF); readCheck("R3 full range");
    doOp(F_DIV, 32'h8000_0000, 32'd0);    readCheck("R6 signed by zero");
    doOp(F_DIVU, 32'hDEAD_BEEF, 32'd0);   readCheck("R6 unsigned by zero");

    // R7: divide latency and busy length, both widths together
    @(negedge clk);
    opFunct = F_DIVU; rsIn = 32'd13; rtIn = 32'd3; opStart = 1'b1;
    doneAtS = 0; doneAtB = 0; busyRunS = 0; busyRunB = 0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      opStart = 1'b0;
      if (busyS) busyRunS++;
      if (busyB) busyRunB++;
      if (doneS && doneAtS == 0) doneAtS = k;
      if (doneB && doneAtB == 0) doneAtB = k;
    end
    updateExp(F_DIVU, 32'd13, 32'd3);
    chk("R7 w4 done cycle", 64'(doneAtS), 64'd6);
    chk("R7 w32 done cycle", 64'(doneAtB), 64'd34);
    chk("R7 w4 busy cycles", 64'(busyRunS), 64'd5);
    chk("R7 w32 busy cycles", 64'(busyRunB), 64'd33);
    readCheck("R7 divide result");

    // R7: multiply pulses done once without busy
    @(negedge clk);
    opFunct = F_MULTU; rsIn = 32'd6; rtIn = 32'd7; opStart = 1'b1;
    @(negedge clk);
    opStart = 1'b0;
    chk("R7 mult done", {doneS, doneB, busyS, busyB}, 4'b1100);
    @(negedge clk);
    chk("R7 mult done single", {doneS, doneB}, 2'b00);
    updateExp(F_MULTU, 32'd6, 32'd7);
    readCheck("R7 mult result");

    // R9 and R10: move-from stalls, other starts ignored while busy
    @(negedge clk);
    opFunct = F_DIVU; rsIn = 32'd14; rtIn = 32'd4; opStart = 1'b1;
    @(negedge clk);
    opFunct = F_MFHI;
    #1;
    chk("R9 stall", {stallS, stallB, readValidS, readValidB}, 4'b1100);
    @(negedge clk);
    opFunct = F_MTHI; rsIn = 32'd5;
    @(negedge clk);
    opFunct = F_MULT; rsIn = 32'd3; rtIn = 32'd3;
    @(negedge clk);
    opFunct = F_MTLO; rsIn = 32'd9;
    @(negedge clk);
    opStart = 1'b0;
    waitIdle();
    updateExp(F_DIVU, 32'd14, 32'd4);
    readCheck("R10 ignored during divide");

    // R9: served when idle
    @(negedge clk);
    opFunct = F_MFLO; opStart = 1'b1;
    #1;
    chk("R9 read valid idle", {readValidS, readValidB, stallS, stallB}, 4'b1100);
    opStart = 1'b0;

    // R11: unknown codes have no effect
    @(negedge clk);
    opFunct = 6'h20; rsIn = 32'd9; rtIn = 32'd9; opStart = 1'b1;
    @(negedge clk);
    opFunct = 6'h1C;
    @(negedge clk);
    opStart = 1'b0;
    chk("R11 no busy or done", {busyS, busyB, doneS, doneB}, 4'b0000);
    readCheck("R11 pair unchanged");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule